// File: doc/BRIEF.md
# Partition Bandwidth Cap Arbiter

This block arbitrates a single downstream memory port among several requesters. It grants at most one request per cycle. Each requester presents a valid bit and the partition it belongs to. For every partition the block counts the grants that partition receives. That count decays by halving at the end of every window of 2^WIN_K cycles. The block compares the decayed count with a per-partition cap, which is a 16-bit unsigned fraction of the port's total capacity.

Each requester is sorted into one of two tiers. A requester whose partition is under its cap sits in the preferred tier. A requester whose partition is over its cap is handled according to that partition's hard flag. With the flag set, the requester is shut out. With the flag clear, it drops to a fallback tier, which is served only when the preferred tier is empty. Each tier has its own round-robin pointer. The over-cap state of every partition is visible on an output vector.

Top module: `bwcap_arbiter`

## Requirements
- R1: After reset, `grant` is zero while no request is valid, and `over_cap` is zero for every partition with a nonzero cap. Both tier pointers start at requester 0, so the first grant goes to the lowest-indexed eligible requester.
- R2: `grant` is one-hot or zero, and it never selects a requester whose `req_valid` bit is low.
- R3: The cap of partition p is `lim_max[p*16 +: 16]`. It is an unsigned fraction with the binary point just above bit 15, so 16'h4000 means one quarter. `over_cap[p]` is 1 when usage × 2^16 > cap × 2^WIN_K, and it is also 1 whenever the cap is zero.
- R4: Usage of a partition rises by one on each clock edge that grants a requester of that partition, and it saturates at its all-ones value. On every 2^WIN_K-th clock edge after reset release, the updated value is halved. The first of these halvings is the 2^WIN_K-th edge.
- R5: While `over_cap[p]` is 1 and `lim_hard[p]` is 1, no requester tagged with partition p is granted. A zero cap with the hard flag set therefore blocks the partition permanently.
- R6: A requester whose partition is over its cap with `lim_hard` clear is granted only in cycles where no valid requester belongs to an under-cap partition.
- R7: Within each tier, the search starts at that tier's pointer and proceeds upward, wrapping around. After a grant, the granting tier's pointer moves to the requester just after the winner, and the other tier's pointer is left unchanged.
- R8: When no requester is eligible in either tier, `grant` is zero for that cycle.
- R9: Requester i's partition is `req_part[i*PID_W +: PID_W]`. Requester i corresponds to bit i of `req_valid` and `grant`. Partition p's hard flag is `lim_hard[p]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_REQ | Request valid, one bit per requester |
| req_part | input | N_REQ*PID_W | Partition tag of each requester |
| lim_max | input | N_PART*16 | Per-partition cap fraction |
| lim_hard | input | N_PART | Per-partition hard-limit flag |
| grant | output | N_REQ | One-hot grant, combinational from the current state |
| over_cap | output | N_PART | Partition usage currently above its cap |

## Verification
The assertions check the following on every cycle:
- The grant is legal: one-hot and never given to an invalid request.
- No hard-limited, over-cap partition is granted.
- A fallback-tier grant happens only while the preferred tier is empty.
- A usage counter never moves down except at a window edge, where it at most halves.

Some behaviour can only be shown by the bench's scenarios:
- The exact grant on which a partition crosses its cap.
- The edge on which the halving readmits a blocked partition.
- The rotation order within each tier.
- Permanent blocking under a zero hard cap.

// File: rtl/bwcap_pkg.sv
package bwcap_pkg;
  localparam int unsigned FRAC_W = 16;
  typedef enum logic {TIER_HI = 1'b0, TIER_LO = 1'b1} tier_e;
endpackage

// File: rtl/bwcap_window.sv
module bwcap_window #(
  parameter int unsigned WIN_K = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic [WIN_K-1:0] tmr_q, tmr_d;

  always_comb begin
    tmr_d = tmr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

  // last cycle of each window
  assign tick = &tmr_q;
endmodule

// File: rtl/bwcap_meter.sv
module bwcap_meter import bwcap_pkg::*; #(
  parameter int unsigned WIN_K = 8,
  parameter int unsigned CNT_W = WIN_K + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              inc,
  input  logic [FRAC_W-1:0] lim,
  output logic              over
);
  localparam int unsigned PROD_W = CNT_W + FRAC_W + 1;

  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_sum;
  logic              cnt_en;
  logic [PROD_W-1:0] use_scaled, cap_scaled;

  always_comb begin
    cnt_sum = (inc && !(&cnt_q)) ? cnt_q + 1'b1 : cnt_q;
    cnt_d   = tick ? (cnt_sum >> 1) : cnt_sum;
    cnt_en  = inc | tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_comb begin
    use_scaled = PROD_W'(cnt_q) << FRAC_W;
    cap_scaled = PROD_W'(lim) << WIN_K;
    over       = (lim == '0) || (use_scaled > cap_scaled);
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> cnt_q >= $past(cnt_q));
  // R4
  cnt_halve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt_q <= ($past(cnt_q) >> 1) + 1'b1);
endmodule

// File: rtl/bwcap_rr_pick.sv
module bwcap_rr_pick #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     elig,
  input  logic [IDX_W-1:0] ptr,
  output logic [N-1:0]     gnt,
  output logic [IDX_W-1:0] win,
  output logic             any
);
  logic [IDX_W-1:0] idx;

  always_comb begin
    gnt = '0;
    win = '0;
    any = 1'b0;
    idx = '0;
    for (int k = 0; k < int'(N); k++) begin
      idx = IDX_W'((int'(ptr) + k) % int'(N));
      if (!any && elig[idx]) begin
        gnt[idx] = 1'b1;
        win      = idx;
        any      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bwcap_arbiter.sv
module bwcap_arbiter import bwcap_pkg::*; #(
  parameter int unsigned N_REQ  = 4,
  parameter int unsigned N_PART = 4,
  parameter int unsigned WIN_K  = 8,
  parameter int unsigned PID_W  = (N_PART > 1) ? $clog2(N_PART) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_REQ-1:0]         req_valid,
  input  logic [N_REQ*PID_W-1:0]   req_part,
  input  logic [N_PART*FRAC_W-1:0] lim_max,
  input  logic [N_PART-1:0]        lim_hard,
  output logic [N_REQ-1:0]         grant,
  output logic [N_PART-1:0]        over_cap
);
  localparam int unsigned IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;
  localparam int unsigned CNT_W = WIN_K + 2;

  logic             tick;
  logic [PID_W-1:0] pid [N_REQ];
  logic [N_REQ-1:0] hi_elig, lo_elig, hi_gnt, lo_gnt;
  logic [IDX_W-1:0] hi_win, lo_win, win_idx;
  logic             hi_any, lo_any, gnt_any;
  logic [IDX_W-1:0] hi_ptr_q, hi_ptr_d, lo_ptr_q, lo_ptr_d;
  logic             ptr_en;
  tier_e            tier_sel;
  logic [N_PART-1:0] part_inc;

  function automatic logic [IDX_W-1:0] ptr_after(input logic [IDX_W-1:0] w);
    return (32'(w) == N_REQ - 1) ? '0 : w + 1'b1;
  endfunction

  bwcap_window #(.WIN_K(WIN_K)) win_u (.clk(clk), .rst_n(rst_n), .tick(tick));

  // Per-requester tier classification
  for (genvar i = 0; i < N_REQ; i++) begin : g_req
    logic pin_range, p_over, p_hard;
    assign pid[i]    = req_part[i*PID_W +: PID_W];
    assign pin_range = 32'(pid[i]) < N_PART;
    assign p_over    = pin_range ? over_cap[pid[i]] : 1'b1;
    assign p_hard    = pin_range ? lim_hard[pid[i]] : 1'b1;
    assign hi_elig[i] = req_valid[i] && !p_over;
    assign lo_elig[i] = req_valid[i] && p_over && !p_hard;

    // R5
    hard_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant[i] |-> !(p_over && p_hard));
    // R6
    soft_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[i] && p_over) |-> (hi_elig == '0));
  end

  bwcap_rr_pick #(.N(N_REQ), .IDX_W(IDX_W)) hi_pick_u (
    .elig(hi_elig), .ptr(hi_ptr_q), .gnt(hi_gnt), .win(hi_win), .any(hi_any));
  bwcap_rr_pick #(.N(N_REQ), .IDX_W(IDX_W)) lo_pick_u (
    .elig(lo_elig), .ptr(lo_ptr_q), .gnt(lo_gnt), .win(lo_win), .any(lo_any));

  // Tier select and pointer next state
  always_comb begin
    tier_sel = hi_any ? TIER_HI : TIER_LO;
    grant    = (tier_sel == TIER_HI) ? hi_gnt : lo_gnt;
    win_idx  = (tier_sel == TIER_HI) ? hi_win : lo_win;
    gnt_any  = hi_any || lo_any;
    ptr_en   = gnt_any;
    hi_ptr_d = hi_ptr_q;
    lo_ptr_d = lo_ptr_q;
    if (tier_sel == TIER_HI) hi_ptr_d = ptr_after(hi_win);
    else if (lo_any)         lo_ptr_d = ptr_after(lo_win);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_ptr_q <= '0;
      lo_ptr_q <= '0;
    end else if (ptr_en) begin
      hi_ptr_q <= hi_ptr_d;
      lo_ptr_q <= lo_ptr_d;
    end
  end

  // Per-partition usage meters
  for (genvar p = 0; p < N_PART; p++) begin : g_part
    assign part_inc[p] = gnt_any && (32'(pid[win_idx]) == p);
    bwcap_meter #(.WIN_K(WIN_K), .CNT_W(CNT_W)) meter_u (
      .clk(clk), .rst_n(rst_n), .tick(tick), .inc(part_inc[p]),
      .lim(lim_max[p*FRAC_W +: FRAC_W]), .over(over_cap[p]));
  end

  // R2
  grant_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~req_valid) == '0));
  // R8
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hi_elig | lo_elig) == '0) |-> (grant == '0));
endmodule

// File: tb/bwcap_arbiter_tb_top.sv
module bwcap_arbiter_tb_top;
  localparam int unsigned N = 4;
  localparam int unsigned K = 4;

  logic        clk, rst_n;
  logic [3:0]  req_valid;
  logic [7:0]  req_part;
  logic [63:0] lim_max;
  logic [3:0]  lim_hard;
  logic [3:0]  grant;
  logic [3:0]  over_cap;
  int vec_cnt = 0;
  int err_cnt = 0;

  bwcap_arbiter #(.N_REQ(N), .N_PART(4), .WIN_K(K)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_part(req_part),
    .lim_max(lim_max), .lim_hard(lim_hard), .grant(grant), .over_cap(over_cap));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {valid[23:20], part[19:12], zero-cap mask[11:8], hard[7:4], expected grant[3:0]}
  localparam logic [23:0] VEC [11] = '{
    24'h0E4000, 24'hFE4001, 24'hEE4002, 24'hFE4112, 24'h1E4110, 24'h1E4101,
    24'h3E4102, 24'h9E4901, 24'hC00104, 24'hC00110, 24'hAE4228};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      err_cnt++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic set_caps(input logic [15:0] m0, input logic [15:0] m1,
                          input logic [15:0] m2, input logic [15:0] m3);
    lim_max = {m3, m2, m1, m0};
  endtask

  initial begin
    #2_000_000;
    err_cnt++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = '0; req_part = 8'hE4; lim_hard = '0;
    set_caps(16'h4000, 16'h4000, 16'h4000, 16'h4000);

    // Tier table from reset state: zero-cap partitions are over (R3, R5, R6, R8, R9)
    for (int v = 0; v < 11; v++) begin
      req_valid = VEC[v][23:20];
      req_part  = VEC[v][19:12];
      lim_hard  = VEC[v][7:4];
      for (int p = 0; p < 4; p++) lim_max[p*16 +: 16] = VEC[v][8+p] ? 16'h0000 : 16'h4000;
      do_reset();
      chk($sformatf("R5/R6/R8 vector %0d grant", v), 32'(grant), 32'(VEC[v][3:0]));
    end

    // R1 reset state
    req_valid = '0; req_part = 8'hE4; lim_hard = '0;
    set_caps(16'h4000, 16'h4000, 16'h4000, 16'h4000);
    do_reset();
    chk("R1 idle grant", 32'(grant), 0);
    chk("R1 over_cap", 32'(over_cap), 0);

    // R7 preferred-tier rotation
    req_valid = 4'hF; #1;
    chk("R1 first grant", 32'(grant), 32'h1);
    for (int k = 0; k < 5; k++) begin
      chk("R7 hi rotation", 32'(grant), 32'(4'b0001 << (k % 4)));
      step();
    end

    // R7 fallback-tier rotation, all on zero-cap soft partition 0
    req_part = 8'h00; set_caps(16'h0000, 16'h4000, 16'h4000, 16'h4000);
    do_reset();
    for (int k = 0; k < 5; k++) begin
      chk("R7 lo rotation", 32'(grant), 32'(4'b0001 << (k % 4)));
      step();
    end

    // R6/R7 preferred tier excludes req0; fallback pointer untouched
    req_part = 8'hE4; do_reset();
    chk("R6 hi first", 32'(grant), 32'h2); step();
    chk("R7 hi next", 32'(grant), 32'h4);  step();
    chk("R7 hi next2", 32'(grant), 32'h8); step();
    chk("R7 hi wrap", 32'(grant), 32'h2);
    req_valid = 4'h1; #1;
    chk("R7 lo pointer still 0", 32'(grant), 32'h1);

    // R3/R4/R5 hard cap of one quarter: over once usage reaches 5
    req_valid = 4'h1; lim_hard = 4'h1;
    set_caps(16'h4000, 16'h4000, 16'h4000, 16'h4000);
    do_reset();
    for (int s = 0; s <= 19; s++) begin
      if (s <= 4 || (s >= 16 && s <= 18)) begin
        chk("R5 granted under cap", 32'(grant), 32'h1);
        chk("R3 not over", 32'(over_cap), 0);
      end else begin
        chk("R5 hard blocked", 32'(grant), 0);
        chk("R4 over held/halved", 32'(over_cap), 32'h1);
      end
      step();
    end

    // R3 finer cap: 1/16 is over at usage 2
    lim_hard = 4'h1; set_caps(16'h1000, 16'h4000, 16'h4000, 16'h4000);
    do_reset();
    step();
    chk("R3 1/16 after one", 32'(over_cap), 0);
    step();
    chk("R3 1/16 after two", 32'(over_cap), 32'h1);

    // R6 soft cap: still served alone, yields to an under-cap requester
    lim_hard = 4'h0; set_caps(16'h4000, 16'h4000, 16'h4000, 16'h4000);
    do_reset();
    repeat (5) step();
    chk("R6 over flag", 32'(over_cap), 32'h1);
    chk("R6 served alone", 32'(grant), 32'h1);
    req_valid = 4'h3; #1;
    chk("R6 defers", 32'(grant), 32'h2);

    // R5/R8 zero hard cap blocks permanently
    begin
      int seen = 0;
      req_valid = 4'h1; lim_hard = 4'h1;
      set_caps(16'h0000, 16'h4000, 16'h4000, 16'h4000);
      do_reset();
      for (int s = 0; s < 40; s++) begin
        if (grant != 0) seen++;
        step();
      end
      chk("R5 zero hard never granted", 32'(seen), 0);
      chk("R3 zero cap over", 32'(over_cap), 32'h1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule